// File: doc/BRIEF.md
# Multichannel DAC Serial Command Front End

This block is the digital front end of a five-channel, 16-bit current-output converter. An SPI master frames each transfer with an active-low chip select. Inside the frame it shifts in a 4-bit operation code, a 4-bit channel address and a 16-bit value, MSB first. A frame may be 24 bits long, or 32 bits with eight leading padding bits. The block acts on the frame only when chip select rises, and only if exactly 24 or 32 clock rising edges were seen. Any other length leaves the block unchanged.

Each channel has two input codes (A and B), two converter codes, a span setting and a power-down flag. Operations can write these registers, copy input codes into converter codes, or do both in one frame. Three level pins act outside the serial protocol. A falling update pin copies every channel's input codes into its converter codes. A low clear pin holds all converter codes at zero. A toggle pin, OR-ed with a software toggle bit, makes enabled channels present their B code.

While a frame is in progress, the serial output returns a snapshot of eight sticky fault flags, then the previous accepted 24-bit word. All pins are resampled into the block clock. Outputs change a few clock cycles after the pin events that cause them.

Top module: `dac_cmd_frontend`

## Requirements
- R1: A frame is bits sampled on rising `spi_sck` while `spi_csn` is low. The last 24 bits are {op[3:0], addr[3:0], data[15:0]}. It is acted on only after `spi_csn` rises. Op 0 writes input code A and leaves the channel's output code unchanged.
- R2: Op 1 copies input codes A and B into the converter codes and clears power-down. Op 3 writes input code A and performs that copy in the same frame.
- R3: A frame with a rising-edge count other than 24 or 32 changes no register. It does not replace the readback word and does not clear fault flags.
- R4: Address 15 selects all channels. Addresses 0 to 4 select one channel. Addresses 5 to 14 select none, so a frame with such an address has no effect.
- R5: Op 6 loads data[3:0] into the addressed channel's span at once. `ch_neg_o` is high exactly when that span equals 4'b1000.
- R6: Op 8 sets the addressed channel's power-down flag. The flag stays set until the next copy into that channel's converter codes (op 1, op 3 or the update pin); the output code is left as it was.
- R7: `spi_sdo_oe` is low while `spi_csn` is high. During a frame, `spi_sdo` (valid at each rising `spi_sck`) gives the 8 fault flags, then the previous accepted 24-bit word. A 24-bit frame therefore carries only the upper 16 bits of that word.
- R8: A fault flag sets whenever its `fault_i` bit is high. When a frame is accepted, each flag is reloaded from the current `fault_i`. A flag raised by a pulse is therefore read once, and is cleared only by the next accepted frame.
- R9: A falling edge on `upd_n` copies input codes A and B into the converter codes of every channel.
- R10: While `clr_n` is low, every converter code A and B is zero. Input codes are kept, so a later update restores them.
- R11: Op 2 writes input code B. Op 12 loads data[k] as the toggle enable of channel k, whatever the address. Op 13 loads data[0] as the software toggle. A channel outputs its B code when it is enabled and either the software toggle or `tgl_pin` is high.
- R12: After reset all codes, spans and power-down flags are zero and `spi_sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad (high-impedance when low) |
| upd_n | input | 1 | Active-low update strobe |
| clr_n | input | 1 | Active-low clear of converter codes |
| tgl_pin | input | 1 | Hardware A/B toggle |
| fault_i | input | 8 | Fault condition inputs |
| ch_code_o | output | 80 | Per-channel active code, channel k at [16k+15:16k] |
| ch_span_o | output | 20 | Per-channel span, channel k at [4k+3:4k] |
| ch_off_o | output | 5 | Per-channel power-down flag |
| ch_neg_o | output | 5 | Per-channel pull-to-negative-rail mode |

## Verification
The hardest states to reach are the fault flag histories. A one-cycle fault pulse, a frame of invalid length and then a valid frame must still return the pulse. A fault that stays present across a read must still show one frame after it goes away. The bench raises `fault_i` for a few cycles between frames and holds it across frame boundaries. It then checks the first readback byte over a series of frames of both valid and invalid length. A table of frames of both lengths checks each readback against the last accepted word, which the bench tracks itself.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int OP_W  = 4;
  localparam int ADR_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_WR_A   = 4'h0,
    OP_UPD    = 4'h1,
    OP_WR_B   = 4'h2,
    OP_WR_UPD = 4'h3,
    OP_SPAN   = 4'h6,
    OP_PDN    = 4'h8,
    OP_TGL_EN = 4'hC,
    OP_TGL_SW = 4'hD,
    OP_NOP    = 4'hF
  } op_e;

  localparam logic [ADR_W-1:0] ADR_ALL = 4'hF;
endpackage

// File: rtl/dacfe_spi.sv
module dacfe_spi #(
  parameter int WORD_W = 24,
  parameter int PAD_W  = 8,
  parameter int FR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic [FR_W-1:0]   flags_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              frame_ok_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int LONG_W = WORD_W + PAD_W;
  localparam int TX_W   = FR_W + WORD_W;
  localparam int CNT_W  = $clog2(LONG_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_W + 1);

  logic [1:0]        sck_q, cs_q;
  logic              sdi_q;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [WORD_W-1:0] rx, rx_nx, prev, prev_nx;
  logic [TX_W-1:0]   tx, tx_nx;
  logic              sck_rise, sck_fall, cs_fall, cs_rise, cs_low, frame_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 2'b00;
      cs_q  <= 2'b11;
      sdi_q <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], sck_i};
      cs_q  <= {cs_q[0], csn_i};
      sdi_q <= sdi_i;
    end
  end

  assign sck_rise = sck_q[0] & ~sck_q[1];
  assign sck_fall = ~sck_q[0] & sck_q[1];
  assign cs_fall  = ~cs_q[0] & cs_q[1];
  assign cs_rise  = cs_q[0] & ~cs_q[1];
  assign cs_low   = ~cs_q[0];
  assign frame_ok = cs_rise &&
                    (cnt == CNT_W'(WORD_W) || cnt == CNT_W'(LONG_W));

  always_comb begin
    cnt_nx  = cnt;
    rx_nx   = rx;
    tx_nx   = tx;
    prev_nx = prev;
    if (cs_fall) begin
      cnt_nx = '0;
      tx_nx  = {flags_i, prev};
    end else if (cs_low) begin
      if (sck_rise) begin
        rx_nx = {rx[WORD_W-2:0], sdi_q};
        if (cnt != CNT_MAX) cnt_nx = cnt + 1'b1;
      end
      if (sck_fall) tx_nx = {tx[TX_W-2:0], 1'b0};
    end
    if (frame_ok) prev_nx = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rx   <= '0;
      tx   <= '0;
      prev <= '0;
    end else begin
      cnt  <= cnt_nx;
      rx   <= rx_nx;
      tx   <= tx_nx;
      prev <= prev_nx;
    end
  end

  assign sdo_o      = tx[TX_W-1];
  assign sdo_oe_o   = cs_low;
  assign frame_ok_o = frame_ok;
  assign word_o     = rx;

  // R7: outside a frame the readback shifter never moves
  p_tx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q == 2'b11) |=> $stable(tx));
  // R3: edge counter saturates instead of wrapping back to a valid length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
endmodule

// File: rtl/dacfe_fault.sv
module dacfe_fault #(
  parameter int FR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FR_W-1:0] fault_i,
  input  logic            frame_ok_i,
  output logic [FR_W-1:0] flags_o
);
  logic [FR_W-1:0] flags, flags_nx;

  always_comb begin
    if (frame_ok_i) flags_nx = fault_i;
    else            flags_nx = flags | fault_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nx;
  end

  assign flags_o = flags;

  // R8: a present condition is always recorded on the next cycle
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(fault_i)) == $past(fault_i)));
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int DAT_W  = 16,
  parameter int SPAN_W = 4,
  parameter logic [SPAN_W-1:0] NEG_CODE = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DAT_W-1:0]  data_i,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic              upd_i,
  input  logic              span_we_i,
  input  logic              pd_i,
  input  logic              tgl_we_i,
  input  logic              tgl_val_i,
  input  logic              tgl_sel_i,
  input  logic              clr_i,
  output logic [DAT_W-1:0]  code_o,
  output logic [SPAN_W-1:0] span_o,
  output logic              off_o,
  output logic              neg_o
);
  logic [DAT_W-1:0]  in_a, in_b, dac_a, dac_b;
  logic [DAT_W-1:0]  in_a_nx, in_b_nx, dac_a_nx, dac_b_nx;
  logic [SPAN_W-1:0] span, span_nx;
  logic              off, off_nx, tgl_en, tgl_en_nx;

  always_comb begin
    in_a_nx   = wr_a_i ? data_i : in_a;
    in_b_nx   = wr_b_i ? data_i : in_b;
    dac_a_nx  = dac_a;
    dac_b_nx  = dac_b;
    off_nx    = off;
    span_nx   = span_we_i ? data_i[SPAN_W-1:0] : span;
    tgl_en_nx = tgl_we_i ? tgl_val_i : tgl_en;
    if (clr_i) begin
      dac_a_nx = '0;
      dac_b_nx = '0;
    end else if (upd_i) begin
      dac_a_nx = in_a_nx;
      dac_b_nx = in_b_nx;
    end
    if (upd_i)     off_nx = 1'b0;
    else if (pd_i) off_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a   <= '0;
      in_b   <= '0;
      dac_a  <= '0;
      dac_b  <= '0;
      span   <= '0;
      off    <= 1'b0;
      tgl_en <= 1'b0;
    end else begin
      in_a   <= in_a_nx;
      in_b   <= in_b_nx;
      dac_a  <= dac_a_nx;
      dac_b  <= dac_b_nx;
      span   <= span_nx;
      off    <= off_nx;
      tgl_en <= tgl_en_nx;
    end
  end

  assign code_o = (tgl_en && tgl_sel_i) ? dac_b : dac_a;
  assign span_o = span;
  assign off_o  = off;
  assign neg_o  = (span == NEG_CODE);

  // R10: clear wins over any update
  p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (dac_a == '0 && dac_b == '0));
  // R6: power-down request without a coincident update sets the flag
  p_pd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_i && !upd_i) |=> off);
  // R2: a plain update transfers the held input code
  p_upd_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clr_i && !wr_a_i) |=> (dac_a == $past(in_a)));
endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
  import dacfe_pkg::*;
#(
  parameter int N_CH   = 5,
  parameter int DAT_W  = 16,
  parameter int SPAN_W = 4,
  parameter int FR_W   = 8,
  parameter int PAD_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sck,
  input  logic                    spi_csn,
  input  logic                    spi_sdi,
  output logic                    spi_sdo,
  output logic                    spi_sdo_oe,
  input  logic                    upd_n,
  input  logic                    clr_n,
  input  logic                    tgl_pin,
  input  logic [FR_W-1:0]         fault_i,
  output logic [N_CH*DAT_W-1:0]   ch_code_o,
  output logic [N_CH*SPAN_W-1:0]  ch_span_o,
  output logic [N_CH-1:0]         ch_off_o,
  output logic [N_CH-1:0]         ch_neg_o
);
  localparam int WORD_W = OP_W + ADR_W + DAT_W;

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [1:0]        upd_q;
  logic              clr_q, tgl_q;
  logic              frame_ok, ldac_fall, sw_tgl, sw_tgl_nx, tgl_sel;
  logic [WORD_W-1:0] word;
  logic [FR_W-1:0]   flags;
  op_e               op;
  logic [ADR_W-1:0]  adr;
  logic [DAT_W-1:0]  dat;
  logic [N_CH-1:0]   hit, wr_a_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      upd_q  <= 2'b11;
      clr_q  <= 1'b1;
      tgl_q  <= 1'b0;
      sw_tgl <= 1'b0;
    end else begin
      upd_q  <= {upd_q[0], upd_n};
      clr_q  <= clr_n;
      tgl_q  <= tgl_pin;
      sw_tgl <= sw_tgl_nx;
    end
  end

  assign ldac_fall = ~upd_q[0] & upd_q[1];
  assign tgl_sel   = tgl_q | sw_tgl;

  dacfe_spi #(.WORD_W(WORD_W), .PAD_W(PAD_W), .FR_W(FR_W)) u_spi (
    .clk(clk), .rst_n(rst_i), .sck_i(spi_sck), .csn_i(spi_csn),
    .sdi_i(spi_sdi), .flags_i(flags), .sdo_o(spi_sdo),
    .sdo_oe_o(spi_sdo_oe), .frame_ok_o(frame_ok), .word_o(word));

  dacfe_fault #(.FR_W(FR_W)) u_fault (
    .clk(clk), .rst_n(rst_i), .fault_i(fault_i),
    .frame_ok_i(frame_ok), .flags_o(flags));

  assign op  = op_e'(word[WORD_W-1 -: OP_W]);
  assign adr = word[DAT_W+ADR_W-1 -: ADR_W];
  assign dat = word[DAT_W-1:0];

  always_comb begin
    sw_tgl_nx = sw_tgl;
    if (frame_ok && op == OP_TGL_SW) sw_tgl_nx = dat[0];
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [DAT_W-1:0]  code_k;
    logic [SPAN_W-1:0] span_k;
    logic              wr_b_k, upd_k, span_we_k, pd_k, tgl_we_k;

    assign hit[k]    = frame_ok && (adr == ADR_W'(k) || adr == ADR_ALL);
    assign wr_a_v[k] = hit[k] && (op == OP_WR_A || op == OP_WR_UPD);
    assign wr_b_k    = hit[k] && (op == OP_WR_B);
    assign upd_k     = (hit[k] && (op == OP_UPD || op == OP_WR_UPD)) || ldac_fall;
    assign span_we_k = hit[k] && (op == OP_SPAN);
    assign pd_k      = hit[k] && (op == OP_PDN);
    assign tgl_we_k  = frame_ok && (op == OP_TGL_EN);

    dacfe_chan #(.DAT_W(DAT_W), .SPAN_W(SPAN_W)) u_chan (
      .clk(clk), .rst_n(rst_i), .data_i(dat), .wr_a_i(wr_a_v[k]),
      .wr_b_i(wr_b_k), .upd_i(upd_k), .span_we_i(span_we_k), .pd_i(pd_k),
      .tgl_we_i(tgl_we_k), .tgl_val_i(dat[k]), .tgl_sel_i(tgl_sel),
      .clr_i(~clr_q), .code_o(code_k), .span_o(span_k),
      .off_o(ch_off_o[k]), .neg_o(ch_neg_o[k]));

    assign ch_code_o[k*DAT_W +: DAT_W]   = code_k;
    assign ch_span_o[k*SPAN_W +: SPAN_W] = span_k;
  end

  // R4: a single-channel address never writes more than one channel
  p_addr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (frame_ok && adr != ADR_ALL) |-> $onehot0(wr_a_v));
  // R4: broadcast write reaches every channel
  p_addr_all_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (frame_ok && adr == ADR_ALL && op == OP_WR_A) |-> ($countones(wr_a_v) == N_CH));
  // R1: nothing is written outside an accepted frame
  p_no_stray_r1: assert property (@(posedge clk) disable iff (!rst_i)
    !frame_ok |-> (hit == '0));
endmodule

// File: tb/test_dac_cmd_frontend.sv
module test_dac_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n, sck, csn, sdi, upd_n, clr_n, tgl_pin;
  logic [7:0]  fault;
  logic        sdo, sdo_oe;
  logic [79:0] code;
  logic [19:0] span;
  logic [4:0]  off, neg;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;
  logic oe_seen;
  logic [23:0] prev_word;

  always #10 clk = ~clk;

  dac_cmd_frontend i_dac_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .upd_n(upd_n), .clr_n(clr_n),
    .tgl_pin(tgl_pin), .fault_i(fault), .ch_code_o(code),
    .ch_span_o(span), .ch_off_o(off), .ch_neg_o(neg));

  typedef struct packed {
    logic [5:0]  nb;
    logic [3:0]  op;
    logic [3:0]  adr;
    logic [15:0] dat;
    logic [2:0]  ch;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{6'd32, 4'h3, 4'h0, 16'h1234, 3'd0, 16'h1234},
    '{6'd24, 4'h0, 4'h1, 16'hABCD, 3'd1, 16'h0000},
    '{6'd24, 4'h1, 4'h1, 16'h0000, 3'd1, 16'hABCD},
    '{6'd32, 4'h3, 4'hF, 16'h5555, 3'd4, 16'h5555},
    '{6'd24, 4'h3, 4'h7, 16'hFFFF, 3'd2, 16'h5555},
    '{6'd32, 4'h0, 4'h2, 16'h0F0F, 3'd2, 16'h5555},
    '{6'd32, 4'h1, 4'hF, 16'h0000, 3'd2, 16'h0F0F},
    '{6'd24, 4'hF, 4'h0, 16'h0000, 3'd0, 16'h5555}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ch_code(input int k);
    return code[k*16 +: 16];
  endfunction

  task automatic xfer(input int nb, input logic [31:0] w, output logic [31:0] rd);
    rd = '0;
    @(negedge clk);
    csn = 1'b0;
    clks(4);
    oe_seen = sdo_oe;
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = (i < 32) ? w[i] : 1'b0;
      clks(4);
      sck = 1'b1;
      rd = {rd[30:0], sdo};
      clks(4);
      sck = 1'b0;
    end
    clks(4);
    csn = 1'b1;
    sdi = 1'b0;
    clks(6);
  endtask

  task automatic send(input int nb, input logic [3:0] op, input logic [3:0] adr,
                      input logic [15:0] dat, output logic [31:0] rd);
    logic [31:0] w;
    w = {8'h00, op, adr, dat};
    xfer(nb, w, rd);
    if (nb == 24 || nb == 32) prev_word = w[23:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; sck = 1'b0; csn = 1'b1; sdi = 1'b0;
    upd_n = 1'b1; clr_n = 1'b1; tgl_pin = 1'b0; fault = 8'h00;
    prev_word = '0;
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R12: reset state
    chk("R12 codes", {16'h0, code[79:64]} | code[31:0], 32'h0);
    chk("R12 spans/off", {span, off, neg}, 32'h0);
    chk("R12 sdo_oe", sdo_oe, 0);

    // Table: R1 R2 R4 functional frames, R7 readback of previous word
    for (int v = 0; v < 8; v++) begin
      logic [23:0] pw;
      pw = prev_word;
      send(VEC[v].nb, VEC[v].op, VEC[v].adr, VEC[v].dat, rd);
      if (VEC[v].nb == 6'd32) chk("R7 readback 32", rd, {8'h00, pw});
      else chk("R7 readback 24", rd[23:0], {8'h00, pw[23:8]});
      chk($sformatf("R1/R2/R4 table row %0d", v), ch_code(VEC[v].ch), VEC[v].exp);
    end
    chk("R7 oe during frame", oe_seen, 1);
    chk("R7 oe idle", sdo_oe, 0);

    // R5 span and negative-rail mode
    send(24, 4'h6, 4'h3, 16'h0008, rd);
    chk("R5 span 8", span[12 +: 4], 4'h8);
    chk("R5 neg set", neg, 5'b01000);
    send(24, 4'h6, 4'h3, 16'h0005, rd);
    chk("R5 span 5", span[12 +: 4], 4'h5);
    chk("R5 neg clear", neg, 5'b00000);

    // R6 power-down
    send(24, 4'h8, 4'h1, 16'h0000, rd);
    chk("R6 off set", off, 5'b00010);
    chk("R6 code kept", ch_code(1), 16'h5555);
    send(24, 4'h1, 4'h1, 16'h0000, rd);
    chk("R6 off cleared by update", off, 5'b00000);

    // R3 invalid lengths
    xfer(20, 32'h0003_9999, rd);
    chk("R3 20-bit ignored", ch_code(0), 16'h5555);
    xfer(25, {8'h00, 4'h3, 4'h0, 16'h9999} << 1, rd);
    chk("R3 25-bit ignored", ch_code(0), 16'h5555);
    begin
      logic [23:0] pw;
      pw = prev_word;
      send(32, 4'hF, 4'h0, 16'h0000, rd);
      chk("R3 readback kept", rd, {8'h00, pw});
    end

    // R8 fault flag behaviour
    fault = 8'h05; clks(3); fault = 8'h00; clks(3);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R8 pulse captured", rd[31:24], 8'h05);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R8 pulse cleared", rd[31:24], 8'h00);
    fault = 8'h80; clks(3);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R8 held read", rd[31:24], 8'h80);
    fault = 8'h00; clks(3);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R8 stays until read absent", rd[31:24], 8'h80);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R8 clears after read", rd[31:24], 8'h00);
    fault = 8'h02; clks(3); fault = 8'h00;
    xfer(20, 32'h0, rd);
    send(32, 4'hF, 4'h0, 16'h0000, rd);
    chk("R3/R8 invalid frame keeps flag", rd[31:24], 8'h02);

    // R9 update pin
    send(24, 4'h0, 4'h0, 16'h1111, rd);
    chk("R1 input only", ch_code(0), 16'h5555);
    upd_n = 1'b0; clks(3); upd_n = 1'b1; clks(4);
    chk("R9 update pin ch0", ch_code(0), 16'h1111);
    chk("R9 update pin ch2", ch_code(2), 16'h0F0F);

    // R10 clear pin
    clr_n = 1'b0; clks(4);
    chk("R10 clear ch0", ch_code(0), 16'h0000);
    chk("R10 clear ch4", ch_code(4), 16'h0000);
    clr_n = 1'b1; clks(3);
    upd_n = 1'b0; clks(3); upd_n = 1'b1; clks(4);
    chk("R10 input kept", ch_code(0), 16'h1111);

    // R11 toggle
    send(24, 4'h2, 4'h0, 16'h2222, rd);
    send(24, 4'h1, 4'h0, 16'h0000, rd);
    chk("R11 not enabled", ch_code(0), 16'h1111);
    send(24, 4'hC, 4'h9, 16'h0001, rd);
    chk("R11 enabled no select", ch_code(0), 16'h1111);
    tgl_pin = 1'b1; clks(4);
    chk("R11 pin selects B", ch_code(0), 16'h2222);
    chk("R11 other channel A", ch_code(1), 16'h5555);
    tgl_pin = 1'b0; clks(4);
    chk("R11 pin released", ch_code(0), 16'h1111);
    send(24, 4'hD, 4'h0, 16'h0001, rd);
    chk("R11 software select", ch_code(0), 16'h2222);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule